// File: doc/BRIEF.md
# Sequential Limb-Serial Wide Integer Multiplier

This block forms the full 448-bit product of two unsigned 224-bit integers. Each operand is treated as seven 32-bit limbs. A single 32x32 multiply-accumulate unit is reused for every limb pair, one pair per clock. The partial sums do not go into a double-width accumulator array. They fold into a seven-word running buffer, and each outer row retires one finished low word of the product.

A client drives both operands and raises `start` while the block is idle. The operands are captured on that edge and `busy` goes high. After 49 step cycles `busy` falls and `done` is high for exactly one cycle. At that point `product` holds the result, and it stays unchanged until the next job completes. The block fits larger arithmetic pipelines, such as prime-field multipliers, that need a compact, fixed-latency wide multiply.

Top module: `mulseq_top`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen at a rising edge while `busy` is low captures `opnd_a` and `opnd_b` on that edge, and `busy` is high from the next cycle on.
- R3: `busy` stays high for exactly 49 cycles per job. `done` is high for exactly one cycle, the first cycle after `busy` falls, and never while `busy` is high.
- R4: When `done` is high, `product` equals the unsigned product of the captured operands. Limb k of an operand is bits 32k+31..32k, and word k of `product` is bits 32k+31..32k.
- R5: While `busy` is high, `start` and any change on `opnd_a`/`opnd_b` have no effect on the job in progress, on its timing or on its result.
- R6: `product` changes only at the edge that raises `done`, and it holds its value between completions.
- R7: Operands of all ones give the exact product 2^448 - 2^225 + 1 with no lost carry. Each limb step a*b + carry + buffer word fits in 64 bits.
- R8: A zero operand gives an all-zero product, whatever value is left over from a previous job.
- R9: A `start` raised during the `done` cycle is accepted, so jobs can run back to back with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| opnd_a | input | 224 | Multiplicand, seven 32-bit limbs, limb 0 lowest |
| opnd_b | input | 224 | Multiplier, seven 32-bit limbs, limb 0 lowest |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 448 | Registered 448-bit product, word 0 lowest |

## Verification
The assertions take for granted that reset is held for at least one edge before any activity. They also assume the client reads `product` only in the `done` cycle or later, because the run-length check counts cycles from an accepted `start`. The stimulus therefore holds reset for several cycles and only begins jobs while `busy` is low. During jobs it deliberately toggles `start` and randomizes the operand inputs, to exercise the hold and ignore behaviour. It also raises `start` in a `done` cycle to cover back-to-back jobs.

// File: rtl/mulseq_pkg.sv
// Package: shared types for the limb-serial multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package mulseq_pkg;

    // Sequencer state: waiting for a job, or stepping limb pairs.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/mulseq_mac.sv
// Module: mulseq_mac
// One limb step: returns the split of a*b + c + d into low and high words.
// Assumes: all inputs are unsigned. The 2W-bit sum cannot overflow, because
// (2^W-1)^2 + 2(2^W-1) = 2^(2W) - 1.
module mulseq_mac #(
    parameter int W = 32
) (
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    input  logic [W-1:0] add_c,
    input  logic [W-1:0] add_d,
    output logic [W-1:0] sum_lo,
    output logic [W-1:0] sum_hi
);
    localparam int DW = 2 * W;

    logic [DW-1:0] prod_w;
    logic [DW-1:0] sum_w;

    // Full-width multiply-accumulate, then split into halves.
    always_comb begin
        prod_w = DW'(mul_a) * DW'(mul_b);
        sum_w  = prod_w + DW'(add_c) + DW'(add_d);
        sum_lo = sum_w[W-1:0];
        sum_hi = sum_w[DW-1:W];
    end

endmodule

// File: rtl/mulseq_ctrl.sv
// Module: mulseq_ctrl
// Sequencer: accepts a job when idle and walks the inner index i, then the
// outer index j, over N x N steps. It raises done for one cycle after the
// last step.
// Assumes: N >= 2. start is sampled only in the idle state.
module mulseq_ctrl
    import mulseq_pkg::*;
#(
    parameter int N     = 7,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             accept,
    output logic             step_en,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_j,
    output logic             first_col,
    output logic             last_col,
    output logic             last_step,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    run_state_e       state_q;
    logic [IDX_W-1:0] i_q;
    logic [IDX_W-1:0] j_q;
    logic             done_q;

    // State, index walk and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            i_q     <= '0;
            j_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        i_q     <= '0;
                        j_q     <= '0;
                    end
                end
                default: begin
                    if (i_q == LAST_IDX) begin
                        i_q <= '0;
                        if (j_q == LAST_IDX) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            j_q <= j_q + IDX_W'(1);
                        end
                    end else begin
                        i_q <= i_q + IDX_W'(1);
                    end
                end
            endcase
        end
    end

    // Decoded status toward the datapath.
    always_comb begin
        busy      = (state_q == ST_RUN);
        accept    = (state_q == ST_IDLE) && start;
        step_en   = busy;
        idx_i     = i_q;
        idx_j     = j_q;
        first_col = (i_q == '0);
        last_col  = (i_q == LAST_IDX);
        last_step = (i_q == LAST_IDX) && (j_q == LAST_IDX);
        done      = done_q;
    end

endmodule

// File: rtl/mulseq_buf.sv
// Module: mulseq_buf
// Running buffer of N words, row carry, retired low words and the product
// register. Step (i, j) takes the MAC result. The low word retires as
// product word j when i = 0; otherwise it goes to buffer word i-1. The high
// word becomes the carry, and on the last column also buffer word N-1.
// Assumes: clear and step_en are never high together.
module mulseq_buf #(
    parameter int W     = 32,
    parameter int N     = 7,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_en,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] idx_j,
    input  logic             first_col,
    input  logic             last_col,
    input  logic             last_step,
    input  logic [W-1:0]     mac_lo,
    input  logic [W-1:0]     mac_hi,
    output logic [W-1:0]     buf_word,
    output logic [W-1:0]     carry_word,
    output logic [2*N*W-1:0] prod_q
);
    localparam int PW = 2 * N * W;

    logic [W-1:0]  run_q  [N];
    logic [W-1:0]  ret_q  [N];
    logic [W-1:0]  run_nx [N];
    logic [W-1:0]  ret_nx [N];
    logic [W-1:0]  carry_q;
    logic [PW-1:0] flat_nx;

    // Buffer word for the current column, and the carry, zero at column 0.
    always_comb begin
        buf_word   = run_q[idx_i];
        carry_word = first_col ? '0 : carry_q;
    end

    // Next-state of the running buffer and the retired words.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            run_nx[k] = run_q[k];
            ret_nx[k] = ret_q[k];
        end
        if (step_en) begin
            if (first_col) begin
                ret_nx[idx_j] = mac_lo;
            end else begin
                run_nx[idx_i - IDX_W'(1)] = mac_lo;
            end
            if (last_col) begin
                run_nx[N-1] = mac_hi;
            end
        end
    end

    // Flatten the next values into the product layout.
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign flat_nx[g*W +: W]     = ret_nx[g];
        assign flat_nx[(N+g)*W +: W] = run_nx[g];
    end

    // Register update: clear on accept, fold on each step, load product at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                run_q[k] <= '0;
                ret_q[k] <= '0;
            end
            carry_q <= '0;
            prod_q  <= '0;
        end else if (clear) begin
            for (int k = 0; k < N; k++) begin
                run_q[k] <= '0;
            end
            carry_q <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                run_q[k] <= run_nx[k];
                ret_q[k] <= ret_nx[k];
            end
            if (step_en) begin
                carry_q <= mac_hi;
            end
            if (step_en && last_step) begin
                prod_q <= flat_nx;
            end
        end
    end

endmodule

// File: rtl/mulseq_top.sv
// Module: mulseq_top
// Limb-serial unsigned multiplier of two N*W-bit operands into a 2*N*W-bit
// product, one MAC step per clock and N*N steps per job.
// Assumes: start is honoured only while busy is low. product is valid from
// the done cycle until the next completion.
module mulseq_top #(
    parameter int W       = 32,
    parameter int N_LIMBS = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [N_LIMBS*W-1:0]     opnd_a,
    input  logic [N_LIMBS*W-1:0]     opnd_b,
    output logic                     busy,
    output logic                     done,
    output logic [2*N_LIMBS*W-1:0]   product
);
    localparam int OPW   = N_LIMBS * W;
    localparam int IDX_W = $clog2(N_LIMBS);

    logic [OPW-1:0]   a_q;
    logic [OPW-1:0]   b_q;
    logic [W-1:0]     a_limb [N_LIMBS];
    logic [W-1:0]     b_limb [N_LIMBS];
    logic             accept;
    logic             step_en;
    logic [IDX_W-1:0] idx_i;
    logic [IDX_W-1:0] idx_j;
    logic             first_col;
    logic             last_col;
    logic             last_step;
    logic [W-1:0]     mac_lo;
    logic [W-1:0]     mac_hi;
    logic [W-1:0]     buf_word;
    logic [W-1:0]     carry_word;

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= opnd_a;
            b_q <= opnd_b;
        end
    end

    // Limb views of the captured operands.
    for (genvar g = 0; g < N_LIMBS; g++) begin : g_limb
        assign a_limb[g] = a_q[g*W +: W];
        assign b_limb[g] = b_q[g*W +: W];
    end

    mulseq_ctrl #(
        .N     (N_LIMBS),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .accept    (accept),
        .step_en   (step_en),
        .idx_i     (idx_i),
        .idx_j     (idx_j),
        .first_col (first_col),
        .last_col  (last_col),
        .last_step (last_step),
        .done      (done)
    );

    mulseq_mac #(
        .W (W)
    ) u_mac (
        .mul_a  (a_limb[idx_i]),
        .mul_b  (b_limb[idx_j]),
        .add_c  (carry_word),
        .add_d  (buf_word),
        .sum_lo (mac_lo),
        .sum_hi (mac_hi)
    );

    mulseq_buf #(
        .W     (W),
        .N     (N_LIMBS),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .step_en    (step_en),
        .idx_i      (idx_i),
        .idx_j      (idx_j),
        .first_col  (first_col),
        .last_col   (last_col),
        .last_step  (last_step),
        .mac_lo     (mac_lo),
        .mac_hi     (mac_hi),
        .buf_word   (buf_word),
        .carry_word (carry_word),
        .prod_q     (product)
    );

endmodule

// File: rtl/mulseq_chk.sv
// Module: mulseq_chk
// Protocol checker for mulseq_top, attached with bind. It counts busy cycles
// from each accepted start, so the run length is checked without deep $past.
// Assumes: reset is asserted before the first job.
module mulseq_chk #(
    parameter int N  = 7,
    parameter int PW = 448
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] product
);
    localparam int CW = $clog2(N * N + 1) + 1;

    logic [CW-1:0] run_cnt;

    // Busy-cycle counter, restarted on each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // R3: completion pulse lasts one cycle.
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done never overlaps busy.
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: exactly N*N busy cycles precede done.
    assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(N * N)));

    // R2: busy only rises after a start.
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: product changes only together with the done pulse.
    assert_prod_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product) |-> done);

    // R5: a start while busy does not cut the job short.
    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind mulseq_top mulseq_chk #(
    .N  (N_LIMBS),
    .PW (2 * N_LIMBS * W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/mulseq_top_tb.sv
// Bench for mulseq_top: a behavioural reference model (countdown and wide
// multiply) is compared with the outputs on every clock, plus directed checks.
module mulseq_top_tb;
    localparam int W     = 32;
    localparam int N     = 7;
    localparam int OPW   = N * W;
    localparam int PW    = 2 * OPW;
    localparam int STEPS = N * N;

    logic           clk;
    logic           rst_n;
    logic           start;
    logic [OPW-1:0] opnd_a;
    logic [OPW-1:0] opnd_b;
    logic           busy;
    logic           done;
    logic [PW-1:0]  product;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state.
    bit             m_busy;
    bit             m_done;
    int             m_left;
    logic [OPW-1:0] m_a;
    logic [OPW-1:0] m_b;
    logic [PW-1:0]  m_prod;

    mulseq_top #(.W(W), .N_LIMBS(N)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [PW-1:0] wide_mul(input logic [OPW-1:0] x, input logic [OPW-1:0] y);
        return PW'(x) * PW'(y);
    endfunction

    function automatic logic [OPW-1:0] rand_op();
        logic [OPW-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0; m_prod = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_prod = wide_mul(m_a, m_b);
                end
            end else if (start) begin
                m_busy = 1;
                m_left = STEPS;
                m_a = opnd_a;
                m_b = opnd_b;
            end
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R3 busy", PW'(busy), PW'(m_busy));
            chk(done == m_done, "R3 done", PW'(done), PW'(m_done));
            chk(product == m_prod, "R4/R6 product", product, m_prod);
        end
    end

    // Run one job; noisy drives start and random operands while busy (R5).
    // back2back raises start in the done cycle for the next job (R9).
    task automatic run_job(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                           input bit noisy, input string tag);
        logic [PW-1:0] exp_p;
        exp_p = wide_mul(a, b);
        while (busy) @(negedge clk);
        opnd_a = a; opnd_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", PW'(busy), PW'(1));
        forever begin
            @(negedge clk);
            if (done) break;
            if (noisy) begin
                opnd_a = rand_op(); opnd_b = rand_op(); start = ~start;
            end
        end
        start = 1'b0;
        chk(product == exp_p, tag, product, exp_p);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", PW'(busy), PW'(0));
        chk(done == 1'b0, "R1 done", PW'(done), PW'(0));
        chk(product == '0, "R1 product", product, '0);
        rst_n = 1'b1;

        run_job(rand_op(), rand_op(), 1'b0, "R4 random job");
        run_job({N{32'h1234_5678}}, {N{32'h9abc_def0}}, 1'b0, "R4 pattern job");
        run_job('1, '1, 1'b0, "R7 all ones");
        chk(product == (PW'(1) - (PW'(1) << (OPW + 1))), "R7 closed form", product,
            PW'(1) - (PW'(1) << (OPW + 1)));
        run_job('0, rand_op(), 1'b0, "R8 zero operand");
        run_job(rand_op(), '1, 1'b1, "R5 noisy inputs while busy");

        // R6: product holds after completion while inputs move.
        begin
            logic [PW-1:0] held;
            held = product;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                opnd_a = rand_op();
                chk(product == held, "R6 hold", product, held);
            end
        end

        // R9: start in the done cycle.
        begin
            logic [OPW-1:0] a2;
            logic [OPW-1:0] b2;
            logic [PW-1:0]  e2;
            run_job(rand_op(), rand_op(), 1'b0, "R4 first of pair");
            a2 = rand_op(); b2 = rand_op(); e2 = wide_mul(a2, b2);
            opnd_a = a2; opnd_b = b2; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 accepted in done cycle", PW'(busy), PW'(1));
            while (!done) @(negedge clk);
            chk(product == e2, "R9 back-to-back product", product, e2);
        end

        for (int t = 0; t < 4; t++) run_job(rand_op(), rand_op(), t[0], "R4 random batch");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule